// File: doc/BRIEF.md
# Matrix Keyboard Read Responder

This block stands in for the passive key matrix of a small home computer. The matrix is seen from a Z80-style processor bus. It holds a pressed/released bit for each key of an 8-row by 5-column grid. A host-side controller sets and clears those bits through a synchronous write port, for example after it has translated a keystroke.

The processor reads the keyboard with an I/O read. In that read, the upper address byte chooses which rows are scanned: each row whose address bit is low takes part. The block answers on the five low data lines with the column states of the chosen rows. A key that is down pulls its column bit to 0. The three upper data lines are left to other logic on the board. The answer is combinational from the bus lines and the stored key state, as a real switch matrix would be. The data-line enable is raised only for the keyboard read decode.

Top module: `kbm_responder`

## Requirements
- R1: After reset every key is released, so every read returns 5'b11111 on the column lines.
- R2: With exactly one row bit low in address bits [15:8] (bit 8+r selects row r), bit c of `bus_data_out` is 0 exactly when key (r, c) is pressed.
- R3: With several row bits low, each column bit is the AND of the selected rows' column values, so a press in any selected row reads as 0.
- R4: With all eight row bits high, `bus_data_out` is 5'b11111 whatever keys are pressed.
- R5: `bus_data_oe` is 1 only while `bus_iorq_n` is 0, `bus_rd_n` is 0 and `bus_addr[0]` is 0. It is 0 for every other combination of those three lines.
- R6: A write with `key_pressed`=1 marks key (`key_row`, `key_col`) pressed, and a write with `key_pressed`=0 marks it released. The change is visible on the next read after the clock edge.
- R7: A `key_clear` pulse releases every key at the next clock edge.
- R8: When `key_clear` and `key_wr` are both high in one cycle, the clear wins and the written key ends up released.
- R9: A write whose `key_col` is 5, 6 or 7 changes no key.
- R10: Reads do not alter the key state. The state changes only through `key_wr` or `key_clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the key-state port |
| rst_n | input | 1 | Active-low reset, releases all keys |
| key_wr | input | 1 | Write strobe for one key |
| key_row | input | 3 | Row index of the key written |
| key_col | input | 3 | Column index of the key written (0..4 valid) |
| key_pressed | input | 1 | 1 = pressed, 0 = released |
| key_clear | input | 1 | Release every key |
| bus_iorq_n | input | 1 | Active-low I/O request |
| bus_rd_n | input | 1 | Active-low read strobe |
| bus_addr | input | 16 | Processor address bus |
| bus_data_out | output | 5 | Column result for data lines 0..4 |
| bus_data_oe | output | 1 | Drive enable for the column lines |

## Verification
The bench presses each of the 40 keys alone and scans every single-row address. This catches a row or column index that is swapped or shifted. Such a fault makes the press show in the wrong row or on the wrong bit. The bench also loads pseudo-random key patterns and applies all 256 upper-address bytes. A merge that ORs the rows, or one that ignores a selected row, would then return 1 where a press should pull the bit low. A merge that lets an unselected row leak through shows up in the no-row case. The bench also covers a write to an out-of-range column, which must not alias onto a real column. It covers clear and write arriving together, where the clear must win. Finally it sweeps all eight strobe combinations, which would expose an enable that ignores one of the three decode terms.

// File: rtl/kbm_pkg.sv
package kbm_pkg;
    localparam int unsigned KBM_ROWS     = 8;
    localparam int unsigned KBM_COLS     = 5;
    localparam int unsigned KBM_ROW_IDXW = $clog2(KBM_ROWS);
    localparam int unsigned KBM_COL_IDXW = 3;

    typedef logic [KBM_COLS-1:0] kbm_colvec_t;

    typedef struct packed {
        logic                    wr;
        logic                    clear;
        logic                    pressed;
        logic [KBM_ROW_IDXW-1:0] row;
        logic [KBM_COL_IDXW-1:0] col;
    } kbm_keycmd_t;
endpackage

// File: rtl/kbm_keystore.sv
module kbm_keystore
    import kbm_pkg::*;
#(
    parameter int unsigned ROWS     = KBM_ROWS,
    parameter int unsigned COLS     = KBM_COLS,
    parameter int unsigned ROW_IDXW = KBM_ROW_IDXW,
    parameter int unsigned COL_IDXW = KBM_COL_IDXW
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_wr,
    input  logic                     cmd_clear,
    input  logic                     cmd_pressed,
    input  logic [ROW_IDXW-1:0]      cmd_row,
    input  logic [COL_IDXW-1:0]      cmd_col,
    output logic [ROWS-1:0][COLS-1:0] row_state
);
    // Stored level per key: 0 = pressed, 1 = released (matrix polarity).
    localparam logic [COLS-1:0] ALL_UP = {COLS{1'b1}};

    logic col_in_range;
    assign col_in_range = (32'(cmd_col) < COLS);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        logic row_hit;
        assign row_hit = cmd_wr && col_in_range && (32'(cmd_row) == r);

        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic key_hit;
            assign key_hit = row_hit && (32'(cmd_col) == c);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    row_state[r][c] <= ALL_UP[c];
                end else if (cmd_clear) begin
                    row_state[r][c] <= ALL_UP[c];
                end else if (key_hit) begin
                    row_state[r][c] <= ~cmd_pressed;
                end
            end
        end
    end
endmodule

// File: rtl/kbm_row_merge.sv
module kbm_row_merge #(
    parameter int unsigned ROWS = 8,
    parameter int unsigned COLS = 5
) (
    input  logic [ROWS-1:0][COLS-1:0] row_state,
    input  logic [ROWS-1:0]           row_sel_n,
    output logic [COLS-1:0]           col_out
);
    logic [ROWS-1:0][COLS-1:0] masked;

    // An unselected row contributes all ones, leaving the AND unchanged.
    for (genvar r = 0; r < ROWS; r++) begin : g_mask
        assign masked[r] = row_sel_n[r] ? {COLS{1'b1}} : row_state[r];
    end

    always_comb begin
        col_out = {COLS{1'b1}};
        for (int r = 0; r < ROWS; r++) begin
            col_out = col_out & masked[r];
        end
    end
endmodule

// File: rtl/kbm_bus_decode.sv
module kbm_bus_decode #(
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned ROWS     = 8,
    parameter int unsigned ROW_BASE = 8
) (
    input  logic              iorq_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [ROWS-1:0]   row_sel_n,
    output logic              port_read
);
    assign row_sel_n = addr[ROW_BASE +: ROWS];
    assign port_read = ~iorq_n & ~rd_n & ~addr[0];
endmodule

// File: rtl/kbm_responder.sv
module kbm_responder
    import kbm_pkg::*;
#(
    parameter int unsigned ROWS     = KBM_ROWS,
    parameter int unsigned COLS     = KBM_COLS,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned ROW_BASE = 8,
    parameter int unsigned COL_IDXW = KBM_COL_IDXW
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          key_wr,
    input  logic [$clog2(ROWS)-1:0]       key_row,
    input  logic [COL_IDXW-1:0]           key_col,
    input  logic                          key_pressed,
    input  logic                          key_clear,
    input  logic                          bus_iorq_n,
    input  logic                          bus_rd_n,
    input  logic [ADDR_W-1:0]             bus_addr,
    output logic [COLS-1:0]               bus_data_out,
    output logic                          bus_data_oe
);
    localparam int unsigned ROW_IDXW = $clog2(ROWS);

    logic [ROWS-1:0][COLS-1:0] row_state;
    logic [ROWS-1:0]           row_sel_n;

    kbm_keystore #(
        .ROWS(ROWS), .COLS(COLS), .ROW_IDXW(ROW_IDXW), .COL_IDXW(COL_IDXW)
    ) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_wr     (key_wr),
        .cmd_clear  (key_clear),
        .cmd_pressed(key_pressed),
        .cmd_row    (key_row),
        .cmd_col    (key_col),
        .row_state  (row_state)
    );

    kbm_bus_decode #(
        .ADDR_W(ADDR_W), .ROWS(ROWS), .ROW_BASE(ROW_BASE)
    ) u_dec (
        .iorq_n   (bus_iorq_n),
        .rd_n     (bus_rd_n),
        .addr     (bus_addr),
        .row_sel_n(row_sel_n),
        .port_read(bus_data_oe)
    );

    kbm_row_merge #(
        .ROWS(ROWS), .COLS(COLS)
    ) u_merge (
        .row_state(row_state),
        .row_sel_n(row_sel_n),
        .col_out  (bus_data_out)
    );
endmodule

// File: rtl/kbm_responder_chk.sv
module kbm_responder_chk #(
    parameter int unsigned ROWS     = 8,
    parameter int unsigned COLS     = 5,
    parameter int unsigned ADDR_W   = 16,
    parameter int unsigned ROW_BASE = 8,
    parameter int unsigned COL_IDXW = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    key_wr,
    input logic [$clog2(ROWS)-1:0] key_row,
    input logic [COL_IDXW-1:0]     key_col,
    input logic                    key_pressed,
    input logic                    key_clear,
    input logic                    bus_iorq_n,
    input logic                    bus_rd_n,
    input logic [ADDR_W-1:0]       bus_addr,
    input logic [COLS-1:0]         bus_data_out,
    input logic                    bus_data_oe
);
    logic [ROWS-1:0] sel_n;
    assign sel_n = bus_addr[ROW_BASE +: ROWS];

    // Last cycle's press of an in-range key, with no clear beside it.
    logic                    press_seen;
    logic [$clog2(ROWS)-1:0] press_row;
    logic [COL_IDXW-1:0]     press_col;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            press_seen <= 1'b0;
            press_row  <= '0;
            press_col  <= '0;
        end else begin
            press_seen <= key_wr && key_pressed && !key_clear && (32'(key_col) < COLS);
            press_row  <= key_row;
            press_col  <= key_col;
        end
    end

    // R5
    iorq_gates_oe_chk: assert property (@(negedge clk) disable iff (!rst_n)
        bus_iorq_n |-> !bus_data_oe);
    // R5
    rd_gates_oe_chk: assert property (@(negedge clk) disable iff (!rst_n)
        bus_rd_n |-> !bus_data_oe);
    // R5
    a0_gates_oe_chk: assert property (@(negedge clk) disable iff (!rst_n)
        bus_addr[0] |-> !bus_data_oe);
    // R4
    idle_rows_high_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (&sel_n) |-> (bus_data_out == {COLS{1'b1}}));
    // R7
    clear_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
        key_clear |=> (bus_data_out == {COLS{1'b1}}));
    // R6
    press_visible_chk: assert property (@(negedge clk) disable iff (!rst_n)
        (press_seen && !sel_n[press_row]) |-> !bus_data_out[press_col]);
    // R10
    state_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!key_wr && !key_clear) |=> ($stable(bus_addr) -> $stable(bus_data_out)));
endmodule

bind kbm_responder kbm_responder_chk #(
    .ROWS(ROWS), .COLS(COLS), .ADDR_W(ADDR_W), .ROW_BASE(ROW_BASE), .COL_IDXW(COL_IDXW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_wr      (key_wr),
    .key_row     (key_row),
    .key_col     (key_col),
    .key_pressed (key_pressed),
    .key_clear   (key_clear),
    .bus_iorq_n  (bus_iorq_n),
    .bus_rd_n    (bus_rd_n),
    .bus_addr    (bus_addr),
    .bus_data_out(bus_data_out),
    .bus_data_oe (bus_data_oe)
);

// File: tb/tb_kbm_responder.sv
module tb_kbm_responder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_wr = 1'b0;
    logic [2:0]  key_row = '0;
    logic [2:0]  key_col = '0;
    logic        key_pressed = 1'b0;
    logic        key_clear = 1'b0;
    logic        bus_iorq_n = 1'b1;
    logic        bus_rd_n = 1'b1;
    logic [15:0] bus_addr = 16'hFFFF;
    logic [4:0]  bus_data_out;
    logic        bus_data_oe;

    int n_vec = 0;
    int n_bad = 0;
    logic [4:0] model [8];

    always #2.5 clk = ~clk;

    kbm_responder dut (
        .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_row(key_row),
        .key_col(key_col), .key_pressed(key_pressed), .key_clear(key_clear),
        .bus_iorq_n(bus_iorq_n), .bus_rd_n(bus_rd_n), .bus_addr(bus_addr),
        .bus_data_out(bus_data_out), .bus_data_oe(bus_data_oe)
    );

    function automatic logic [4:0] expect_cols(input logic [7:0] sel_n);
        logic [4:0] v = 5'h1F;
        for (int r = 0; r < 8; r++) if (!sel_n[r]) v = v & model[r];
        return v;
    endfunction

    task automatic chk(input string req, input logic [4:0] got, input logic [4:0] exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %05b expected %05b", req, got, exp);
        end
    endtask

    // Write one key; the stored level becomes visible after the posedge.
    task automatic put_key(input int r, input int c, input logic p);
        @(negedge clk);
        key_wr = 1'b1; key_row = 3'(r); key_col = 3'(c); key_pressed = p;
        @(negedge clk);
        key_wr = 1'b0;
        if (c < 5) model[r][c] = ~p;
    endtask

    task automatic clear_all();
        @(negedge clk);
        key_clear = 1'b1;
        @(negedge clk);
        key_clear = 1'b0;
        for (int r = 0; r < 8; r++) model[r] = 5'h1F;
    endtask

    task automatic read_at(input string req, input logic [7:0] hi);
        bus_iorq_n = 1'b0; bus_rd_n = 1'b0; bus_addr = {hi, 8'hFE};
        #1;
        chk(req, bus_data_out, expect_cols(hi));
    endtask

    task automatic scan_single(input string req);
        for (int r = 0; r < 8; r++) read_at(req, ~(8'h01 << r));
    endtask

    initial begin
        #(200000 * 5);
        n_vec++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lfsr = 16'hACE1;
        for (int r = 0; r < 8; r++) model[r] = 5'h1F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, every row and the full select
        scan_single("R1");
        read_at("R1", 8'h00);

        // R2, R6: each key alone against every single-row scan
        for (int r = 0; r < 8; r++) begin
            for (int c = 0; c < 5; c++) begin
                put_key(r, c, 1'b1);
                scan_single("R2");
                put_key(r, c, 1'b0);
                read_at("R6", ~(8'h01 << r));
            end
        end

        // R3, R4, R10: random patterns, all 256 upper-address bytes
        for (int p = 0; p < 12; p++) begin
            for (int k = 0; k < 6; k++) begin
                lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                put_key(int'(lfsr[2:0]), int'(lfsr[7:4]) % 5, lfsr[9]);
            end
            for (int a = 0; a < 256; a++) begin
                read_at((a == 255) ? "R4" : "R3", 8'(a));
            end
            read_at("R10", 8'h00);
        end

        // R9: out-of-range columns leave the pattern untouched
        clear_all();
        for (int c = 5; c < 8; c++) put_key(2, c, 1'b1);
        scan_single("R9");

        // R7: clear after many presses
        for (int r = 0; r < 8; r++) put_key(r, r % 5, 1'b1);
        clear_all();
        read_at("R7", 8'h00);

        // R8: clear and write in the same cycle
        @(negedge clk);
        key_wr = 1'b1; key_row = 3'd4; key_col = 3'd1; key_pressed = 1'b1; key_clear = 1'b1;
        @(negedge clk);
        key_wr = 1'b0; key_clear = 1'b0;
        read_at("R8", 8'hEF);

        // R5: enable over the eight strobe combinations
        put_key(0, 0, 1'b1);
        for (int s = 0; s < 8; s++) begin
            bus_iorq_n = s[0]; bus_rd_n = s[1]; bus_addr = {8'hFE, 7'h7F, s[2]};
            #1;
            chk("R5", {4'b0, bus_data_oe}, {4'b0, (s == 0)});
            @(negedge clk);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule